// File: doc/BRIEF.md
# Packetised Register Access Engine

The engine sits downstream of an error-correcting packet decoder. It receives the 11 information bits of each corrected host packet and turns a short sequence of these packets into read and write accesses on a 4096-entry, 16-bit register file. A transaction opens with a command packet, which carries the access flags and the bottom nibble of the address. An address packet follows with the upper eight address bits. Then come one or two data-slot packets for each register touched. Every packet carries a two-bit identifier, and the engine checks it against the slot it expects next.

A write places the byte carried in each slot into the selected half of the register. A word write commits both halves in a single register-file write. For a read, the host sends the same data-slot packets, and their contents are ignored. The engine answers each one with an 11-bit response payload that it hands to the check-bit encoder. A low-slot response carries bits 9..0 of the register and a high-slot response carries bits 15..6, so the two slices overlap. With auto-increment set, the address steps by one after each register, so a burst costs one or two packets per further register. A corrupted or out-of-order packet never reaches the register file. An identifier out of sequence also raises a sticky protocol-error flag.

Top module: `pkt_reg_engine`

## Requirements
- R1: After reset, rsp_valid, reg_wr_en, reg_rd_en and proto_err are all 0, and the engine expects a command packet.
- R2: Packet field layout of pkt_bits:
  - bit 0 is 0 for a host packet.
  - bits 2:1 hold the packet ID: 0 = command, 1 = address, 2 = low slot, 3 = high slot.
  - In a command packet, bit 3 = read, bit 4 = low byte selected, bit 5 = high byte selected, bit 6 = auto-increment, and bits 10:7 = address bits 3:0.
  - An address packet carries address bits 11:4 in bits 10:3.
  - A slot packet carries a data byte in bits 10:3.
- R3: A word write takes four packets: command, address, low slot, high slot. The register is written once, with both byte enables set (reg_wr_be = 2'b11), in the cycle the high-slot packet is accepted. No write happens on the low slot.
- R4: A byte write takes three packets. A low-only write uses slot ID 2 and reg_wr_be = 2'b01. A high-only write uses slot ID 3 and reg_wr_be = 2'b10. The other half of the register keeps its value.
- R5: A read sends command and address packets, then one slot packet per selected byte: ID 2 for low, ID 3 for high, and both in that order for a word. The register read is issued in the cycle the address becomes complete. The payload of a read slot packet is ignored.
- R6: One cycle after each accepted read slot packet, rsp_valid pulses and rsp_payload bit 0 is 1.
  - For a low slot, bit 1 = D8, bit 2 = D9 and bits 10:3 = D7..D0 (bit 3 = D0).
  - For a high slot, bits 10:1 = D15..D6 (bit 1 = D6).
- R7: With auto-increment set, the address rises by one after the last slot of each register. The engine then expects the first slot of the next register, so each further register costs one packet (byte access) or two packets (word access).
- R8: Auto-increment wraps the address from 0xFFF to 0x000.
- R9: In an auto-increment burst, a command packet that arrives at a register boundary ends the burst and starts a new transaction without a protocol error.
- R10: A packet with pkt_uncorr = 1 is ignored. It causes no register access and no response, and it does not change the expected ID.
- R11: A packet with bit 0 = 1 is ignored in the same way as an uncorrectable packet.
- R12: A packet whose ID is not the expected one aborts the transaction with no register access and sets proto_err. proto_err stays set until reset. The engine returns to expecting a command packet, and the offending packet is not reinterpreted.
- R13: A command packet with neither byte selected (bits 5:4 = 00) sets proto_err and leaves the engine expecting a command packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A corrected packet is present this cycle |
| pkt_bits | input | 11 | Information bits of the corrected packet |
| pkt_uncorr | input | 1 | Decoder flagged the packet as uncorrectable |
| reg_addr | output | 12 | Register file address |
| reg_wr_en | output | 1 | Register file write strobe |
| reg_wr_be | output | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| reg_wdata | output | 16 | Register file write data |
| reg_rd_en | output | 1 | Register file read strobe |
| reg_rdata | input | 16 | Read data, valid one cycle after reg_rd_en and held until the next read |
| rsp_valid | output | 1 | Response payload valid for one cycle |
| rsp_payload | output | 11 | Response information bits for the check-bit encoder |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest state to reach is a register boundary inside an auto-increment burst. Here the engine accepts either the next slot or a fresh command, and the address may be about to wrap past 0xFFF. The stimulus gets there with directed bursts that start two registers below the top of the address space. It also runs bursts that a new command cuts off mid-stream, and injects uncorrectable and device-direction packets between slots. On top of that, fixed-seed random write-then-read-back transactions mix every byte selection, burst length and address. All response payloads and register contents are predicted from a bench-side model of the register file.

// File: rtl/pre_pkg.sv
package pre_pkg;
  localparam int PAY_W   = 11;
  localparam int ID_W    = 2;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int ID_LSB  = 1;
  localparam int FLD_LSB = ID_LSB + ID_W;
  localparam int NIB_LSB = FLD_LSB + NIB_W;

  typedef enum logic [ID_W-1:0] {
    PID_CMD  = 2'd0,
    PID_ADDR = 2'd1,
    PID_LO   = 2'd2,
    PID_HI   = 2'd3
  } pid_e;

  // packed order mirrors packet bits 6..3
  typedef struct packed {
    logic autoinc;
    logic hi;
    logic lo;
    logic rd;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_ADDR,
    ST_LO,
    ST_HI
  } st_e;
endpackage

// File: rtl/pre_pkt_decode.sv
module pre_pkt_decode
  import pre_pkg::*;
(
  input  logic             pkt_valid,
  input  logic             pkt_uncorr,
  input  logic [PAY_W-1:0] pkt_bits,
  output logic             acc,
  output pid_e             id,
  output logic [BYTE_W-1:0] fld,
  output cmd_t             cmd,
  output logic [NIB_W-1:0] nib
);
  // a packet counts only if intact and host-directed (bit 0 clear)
  assign acc = pkt_valid & ~pkt_uncorr & ~pkt_bits[0];
  assign id  = pid_e'(pkt_bits[ID_LSB +: ID_W]);
  assign fld = pkt_bits[FLD_LSB +: BYTE_W];
  assign cmd = cmd_t'(pkt_bits[FLD_LSB +: NIB_W]);
  assign nib = pkt_bits[NIB_LSB +: NIB_W];
endmodule

// File: rtl/pre_rsp_build.sv
module pre_rsp_build
  import pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              slot_hi,
  input  logic [DATA_W-1:0] rdata,
  output logic              rsp_valid,
  output logic [PAY_W-1:0]  rsp_payload
);
  localparam int SLICE_W = PAY_W - 1;
  localparam int EXTRA_W = SLICE_W - BYTE_W;

  logic [PAY_W-1:0] pay_d;
  logic [PAY_W-1:0] pay_q;
  logic             vld_q;

  always_comb begin
    if (slot_hi) begin
      pay_d = {rdata[DATA_W-1 -: SLICE_W], 1'b1};
    end else begin
      pay_d = {rdata[BYTE_W-1:0], rdata[BYTE_W +: EXTRA_W], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        pay_q <= pay_d;
      end
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_payload = pay_q;
endmodule

// File: rtl/pre_txn_ctrl.sv
module pre_txn_ctrl
  import pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  pid_e              id,
  input  logic [BYTE_W-1:0] fld,
  input  cmd_t              cmd,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en,
  output logic [1:0]        wr_be,
  output logic [DATA_W-1:0] wdata,
  output logic              rd_en,
  output logic              rsp_load,
  output logic              rsp_hi,
  output logic              err_o
);
  st_e               st_q, st_d;
  cmd_t              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] lobuf_q, lobuf_d;
  logic              gap_q, gap_d;
  logic              err_q, err_d;
  logic              do_start, do_fin, do_err;

  always_comb begin
    st_d     = st_q;
    cmd_d    = cmd_q;
    addr_d   = addr_q;
    lobuf_d  = lobuf_q;
    gap_d    = gap_q;
    err_d    = err_q;
    wr_en    = 1'b0;
    wr_be    = 2'b00;
    wdata    = {fld, fld};
    rd_en    = 1'b0;
    addr_o   = addr_q;
    rsp_load = 1'b0;
    rsp_hi   = 1'b0;
    do_start = 1'b0;
    do_fin   = 1'b0;
    do_err   = 1'b0;
    if (acc) begin
      case (st_q)
        ST_CMD: begin
          if (id == PID_CMD) do_start = 1'b1;
          else               do_err   = 1'b1;
        end
        ST_ADDR: begin
          if (id == PID_ADDR) begin
            addr_d = {fld, addr_q[NIB_W-1:0]};
            st_d   = cmd_q.lo ? ST_LO : ST_HI;
            if (cmd_q.rd) begin
              rd_en  = 1'b1;
              addr_o = addr_d;
            end
          end else begin
            do_err = 1'b1;
          end
        end
        ST_LO: begin
          if (id == PID_LO) begin
            gap_d = 1'b0;
            if (cmd_q.rd) begin
              rsp_load = 1'b1;
            end else if (cmd_q.hi) begin
              lobuf_d = fld;
            end else begin
              wr_en = 1'b1;
              wr_be = 2'b01;
            end
            if (cmd_q.hi) st_d   = ST_HI;
            else          do_fin = 1'b1;
          end else if (id == PID_CMD && gap_q) begin
            do_start = 1'b1;
          end else begin
            do_err = 1'b1;
          end
        end
        ST_HI: begin
          if (id == PID_HI) begin
            gap_d = 1'b0;
            if (cmd_q.rd) begin
              rsp_load = 1'b1;
              rsp_hi   = 1'b1;
            end else begin
              wr_en = 1'b1;
              wr_be = cmd_q.lo ? 2'b11 : 2'b10;
              wdata = {fld, cmd_q.lo ? lobuf_q : fld};
            end
            do_fin = 1'b1;
          end else if (id == PID_CMD && gap_q) begin
            do_start = 1'b1;
          end else begin
            do_err = 1'b1;
          end
        end
        default: do_err = 1'b1;
      endcase

      if (do_fin) begin
        if (cmd_q.autoinc) begin
          addr_d = addr_q + ADDR_W'(1);
          gap_d  = 1'b1;
          st_d   = cmd_q.lo ? ST_LO : ST_HI;
          if (cmd_q.rd) begin
            rd_en  = 1'b1;
            addr_o = addr_d;
          end
        end else begin
          st_d  = ST_CMD;
          gap_d = 1'b0;
        end
      end

      if (do_start) begin
        gap_d = 1'b0;
        if (cmd.lo | cmd.hi) begin
          cmd_d  = cmd;
          addr_d = {addr_q[ADDR_W-1:NIB_W], nib};
          st_d   = ST_ADDR;
        end else begin
          do_err = 1'b1;
        end
      end

      if (do_err) begin
        err_d = 1'b1;
        st_d  = ST_CMD;
        gap_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CMD;
      cmd_q   <= '0;
      addr_q  <= '0;
      lobuf_q <= '0;
      gap_q   <= 1'b0;
      err_q   <= 1'b0;
    end else if (acc) begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      lobuf_q <= lobuf_d;
      gap_q   <= gap_d;
      err_q   <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pkt_reg_engine.sv
module pkt_reg_engine
  import pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [PAY_W-1:0]  pkt_bits,
  input  logic              pkt_uncorr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [1:0]        reg_wr_be,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rsp_valid,
  output logic [PAY_W-1:0]  rsp_payload,
  output logic              proto_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              acc;
  pid_e              id;
  logic [BYTE_W-1:0] fld;
  cmd_t              cmd;
  logic [NIB_W-1:0]  nib;
  logic              rsp_load;
  logic              rsp_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pre_pkt_decode u_dec (
    .pkt_valid (pkt_valid),
    .pkt_uncorr(pkt_uncorr),
    .pkt_bits  (pkt_bits),
    .acc       (acc),
    .id        (id),
    .fld       (fld),
    .cmd       (cmd),
    .nib       (nib)
  );

  pre_txn_ctrl u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .acc     (acc),
    .id      (id),
    .fld     (fld),
    .cmd     (cmd),
    .nib     (nib),
    .addr_o  (reg_addr),
    .wr_en   (reg_wr_en),
    .wr_be   (reg_wr_be),
    .wdata   (reg_wdata),
    .rd_en   (reg_rd_en),
    .rsp_load(rsp_load),
    .rsp_hi  (rsp_hi),
    .err_o   (proto_err)
  );

  pre_rsp_build u_rsp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (rsp_load),
    .slot_hi    (rsp_hi),
    .rdata      (reg_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_payload(rsp_payload)
  );
endmodule

// File: rtl/pre_checker.sv
module pre_checker
  import pre_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic [PAY_W-1:0] pkt_bits,
  input logic             pkt_uncorr,
  input logic             reg_wr_en,
  input logic [1:0]       reg_wr_be,
  input logic             reg_rd_en,
  input logic             rsp_valid,
  input logic             proto_err
);
  assert_no_access_uncorr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_uncorr) |-> (!reg_wr_en && !reg_rd_en));

  assert_no_rsp_uncorr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_uncorr) |=> !rsp_valid);

  assert_ignore_device_pkt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_bits[0]) |-> (!reg_wr_en && !reg_rd_en));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_write_needs_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (pkt_valid && !pkt_uncorr && !pkt_bits[0]));

  assert_write_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> pkt_bits[2]);

  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_be != 2'b00));

  assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  assert_rsp_after_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid || pkt_uncorr) |=> !rsp_valid);
endmodule

bind pkt_reg_engine pre_checker u_chk (.*);

// File: tb/tb_pkt_reg_engine.sv
module tb_pkt_reg_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic [10:0] pkt_bits;
  logic        pkt_uncorr;
  logic [11:0] reg_addr;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_be;
  logic [15:0] reg_wdata;
  logic        reg_rd_en;
  logic [15:0] reg_rdata;
  logic        rsp_valid;
  logic [10:0] rsp_payload;
  logic        proto_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic        wr_seen, rd_seen, got_v;
  logic [10:0] got_p;

  logic [15:0] mem [int];
  logic [15:0] ref_mem [int];

  always #2 clk = ~clk;

  pkt_reg_engine dut (.*);

  function automatic logic [15:0] mget(input logic [11:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_get(input logic [11:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  // R6 response layouts
  function automatic logic [10:0] exp_lo(input logic [15:0] d);
    return {d[7:0], d[9], d[8], 1'b1};
  endfunction

  function automatic logic [10:0] exp_hi(input logic [15:0] d);
    return {d[15:6], 1'b1};
  endfunction

  // register file model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= 16'h0000;
    end else begin
      if (reg_wr_en) begin
        logic [15:0] o;
        o = mget(reg_addr);
        if (reg_wr_be[0]) o[7:0]  = reg_wdata[7:0];
        if (reg_wr_be[1]) o[15:8] = reg_wdata[15:8];
        mem[int'(reg_addr)] = o;
      end
      if (reg_rd_en) reg_rdata <= mget(reg_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] id, input logic [7:0] pl,
                      input logic unc, input logic dir);
    @(negedge clk);
    pkt_valid  = 1'b1;
    pkt_bits   = {pl, id, dir};
    pkt_uncorr = unc;
    #1;
    wr_seen = reg_wr_en;
    rd_seen = reg_rd_en;
    @(negedge clk);
    got_v = rsp_valid;
    got_p = rsp_payload;
    pkt_valid  = 1'b0;
    pkt_uncorr = 1'b0;
    pkt_bits   = 11'($urandom);
  endtask

  function automatic logic [7:0] cmdb(input bit rd, input bit lo, input bit hi,
                                      input bit au, input logic [11:0] a);
    return {a[3:0], au, hi, lo, rd};
  endfunction

  task automatic do_write(input logic [11:0] addr, input bit lo, input bit hi,
                          input bit au, input int n, input string req);
    send(2'd0, cmdb(1'b0, lo, hi, au, addr), 1'b0, 1'b0);
    send(2'd1, addr[11:4], 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [11:0] a;
      logic [15:0] d, e;
      a = addr + 12'(i);
      d = 16'($urandom);
      if (lo) begin
        send(2'd2, d[7:0], 1'b0, 1'b0);
        if (hi) chk(!wr_seen, req, "write on low slot of word", 32'(wr_seen), 0);
      end
      if (hi) send(2'd3, d[15:8], 1'b0, 1'b0);
      e = ref_get(a);
      if (lo) e[7:0]  = d[7:0];
      if (hi) e[15:8] = d[15:8];
      ref_mem[int'(a)] = e;
      chk(mget(a) == e, req, "register content", 32'(mget(a)), 32'(e));
    end
  endtask

  task automatic do_read(input logic [11:0] addr, input bit lo, input bit hi,
                         input bit au, input int n, input string req);
    send(2'd0, cmdb(1'b1, lo, hi, au, addr), 1'b0, 1'b0);
    send(2'd1, addr[11:4], 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [11:0] a;
      a = addr + 12'(i);
      if (lo) begin
        send(2'd2, 8'($urandom), 1'b0, 1'b0);
        chk(got_v && got_p == exp_lo(ref_get(a)), req, "low response",
            {20'h0, got_v, got_p}, {20'h0, 1'b1, exp_lo(ref_get(a))});
      end
      if (hi) begin
        send(2'd3, 8'($urandom), 1'b0, 1'b0);
        chk(got_v && got_p == exp_hi(ref_get(a)), req, "high response",
            {20'h0, got_v, got_p}, {20'h0, 1'b1, exp_hi(ref_get(a))});
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    pkt_valid = 1'b0;
    pkt_bits = '0;
    pkt_uncorr = 1'b0;
    wr_seen = 0; rd_seen = 0; got_v = 0; got_p = '0;
    do_reset();

    // R1 reset state
    chk(!rsp_valid && !reg_wr_en && !reg_rd_en && !proto_err, "R1", "reset outputs",
        {rsp_valid, reg_wr_en, reg_rd_en, proto_err}, 0);

    // R2 R3 R5 R6 directed word and byte accesses
    do_write(12'h123, 1, 1, 0, 1, "R2");
    do_write(12'h123, 1, 1, 0, 1, "R3");
    do_read(12'h123, 1, 1, 0, 1, "R5");
    do_read(12'h123, 1, 0, 0, 1, "R6");
    do_read(12'h123, 0, 1, 0, 1, "R6");
    // R4 byte writes preserve the other half
    do_write(12'h123, 1, 0, 0, 1, "R4");
    do_write(12'h123, 0, 1, 0, 1, "R4");
    do_read(12'h123, 1, 1, 0, 1, "R4");

    // R7 bursts
    do_write(12'h040, 1, 1, 1, 4, "R7");
    do_read(12'h040, 1, 1, 1, 4, "R7");
    do_write(12'h080, 0, 1, 1, 3, "R7");
    do_read(12'h080, 1, 0, 1, 3, "R7");

    // R8 wrap past the top address
    do_write(12'hFFE, 1, 1, 1, 3, "R8");
    do_read(12'hFFE, 1, 1, 1, 3, "R8");
    chk(mget(12'h000) == ref_get(12'h000), "R8", "wrapped register",
        32'(mget(12'h000)), 32'(ref_get(12'h000)));

    // R9 new command ends a burst cleanly
    do_write(12'h200, 1, 0, 1, 2, "R9");
    do_write(12'h300, 0, 1, 0, 1, "R9");
    do_read(12'h200, 1, 1, 1, 2, "R9");
    do_read(12'h300, 0, 1, 0, 1, "R9");
    chk(!proto_err, "R9", "no error on burst end", 32'(proto_err), 0);

    // R10 uncorrectable packets are dropped
    send(2'd1, 8'h55, 1'b1, 1'b0);
    send(2'd0, cmdb(1'b0, 1'b1, 1'b1, 1'b0, 12'h400), 1'b0, 1'b0);
    send(2'd1, 8'h40, 1'b0, 1'b0);
    send(2'd3, 8'hAA, 1'b1, 1'b0);
    chk(!wr_seen && !got_v, "R10", "access on uncorrectable", {wr_seen, got_v}, 0);
    send(2'd2, 8'h11, 1'b0, 1'b0);
    send(2'd3, 8'h22, 1'b0, 1'b0);
    ref_mem[32'h400] = 16'h2211;
    chk(mget(12'h400) == 16'h2211, "R10", "write after dropped packet",
        32'(mget(12'h400)), 32'h2211);
    send(2'd0, cmdb(1'b1, 1'b1, 1'b0, 1'b0, 12'h400), 1'b0, 1'b0);
    send(2'd1, 8'h40, 1'b0, 1'b0);
    send(2'd2, 8'h00, 1'b1, 1'b0);
    chk(!got_v, "R10", "response to uncorrectable", 32'(got_v), 0);
    send(2'd2, 8'h00, 1'b0, 1'b0);
    chk(got_v && got_p == exp_lo(16'h2211), "R10", "read after dropped packet",
        {got_v, got_p}, {1'b1, exp_lo(16'h2211)});
    chk(!proto_err, "R10", "no error from dropped packets", 32'(proto_err), 0);

    // R11 device-direction packets are dropped
    send(2'd0, cmdb(1'b0, 1'b1, 1'b0, 1'b0, 12'h401), 1'b0, 1'b0);
    send(2'd1, 8'h40, 1'b0, 1'b0);
    send(2'd3, 8'hC3, 1'b0, 1'b1);
    chk(!wr_seen && !proto_err, "R11", "reaction to bit0=1", {wr_seen, proto_err}, 0);
    send(2'd2, 8'h5A, 1'b0, 1'b0);
    ref_mem[32'h401] = {ref_get(12'h401) >> 8, 8'h5A};
    chk(mget(12'h401) == ref_get(12'h401), "R11", "write after ignored packet",
        32'(mget(12'h401)), 32'(ref_get(12'h401)));

    // random write-then-read mix
    for (int k = 0; k < 120; k++) begin
      logic [11:0] a;
      logic [1:0] s1, s2;
      bit au;
      int n;
      string rq;
      a  = 12'($urandom);
      s1 = 2'(1 + $urandom % 3);
      s2 = 2'(1 + $urandom % 3);
      au = 1'($urandom);
      n  = au ? 1 + int'($urandom % 4) : 1;
      rq = au ? "R7" : ((s1 == 2'b11) ? "R3" : "R4");
      do_write(a, s1[0], s1[1], au, n, rq);
      do_read(a, s2[0], s2[1], au, n, au ? "R7" : "R6");
    end
    chk(!proto_err, "R9", "no error during random mix", 32'(proto_err), 0);

    // R12 out-of-order ID aborts
    do_write(12'h500, 1, 1, 0, 1, "R12");
    send(2'd0, cmdb(1'b0, 1'b1, 1'b1, 1'b0, 12'h500), 1'b0, 1'b0);
    send(2'd1, 8'h50, 1'b0, 1'b0);
    send(2'd2, 8'h77, 1'b0, 1'b0);
    send(2'd1, 8'h99, 1'b0, 1'b0);
    chk(proto_err && !wr_seen, "R12", "error on ID mismatch", {proto_err, wr_seen}, 2'b10);
    send(2'd3, 8'h88, 1'b0, 1'b0);
    chk(!wr_seen && proto_err, "R12", "aborted slot not written", {proto_err, wr_seen}, 2'b10);
    chk(mget(12'h500) == ref_get(12'h500), "R12", "register untouched",
        32'(mget(12'h500)), 32'(ref_get(12'h500)));
    do_write(12'h500, 1, 1, 0, 1, "R12");
    do_reset();
    chk(!proto_err && !rsp_valid, "R1", "reset clears error", {proto_err, rsp_valid}, 0);

    // R13 command without a byte selection
    send(2'd0, cmdb(1'b0, 1'b0, 1'b0, 1'b0, 12'h600), 1'b0, 1'b0);
    chk(proto_err, "R13", "error on empty select", 32'(proto_err), 1);
    send(2'd1, 8'h60, 1'b0, 1'b0);
    send(2'd2, 8'h60, 1'b0, 1'b0);
    chk(!wr_seen && !rd_seen, "R13", "no access after empty select", {wr_seen, rd_seen}, 0);
    do_write(12'h600, 1, 1, 0, 1, "R13");
    do_read(12'h600, 1, 1, 0, 1, "R13");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule